// File: doc/BRIEF.md
# Scaled VGA Sync Timing Generator

This block produces the raster timing for an 800×600, 60 Hz display mode when the pixel clock is 10 MHz instead of the customary 40 MHz. The horizontal timing is shrunk by a factor of four, so each scanline is 264 clocks long. A line counter advances once per finished scanline, and 628 lines make one frame. The result is a line rate near 37.8 kHz and a frame rate near 60 Hz.

Each timing interval is held in its own set/clear register. The register is set when the counter's next value equals the interval's first count and cleared when it equals the first count past the interval. No magnitude comparator is used. Both sync outputs are active-high and come straight from registers, so they carry no decode glitches.

Display enable is the AND of the horizontal and vertical visible flags. A registered end-of-frame strobe marks the last pixel of each frame. The host logic uses the counts to fetch pixel data and uses display enable to blank that data outside the visible area.

Top module: `scan_timing_gen`

## Requirements
- R1: The pixel count steps by one on every clock, runs from 0 to 263 (H_ACTIVE+H_FRONT+H_SYNC+H_BACK−1) and then returns to 0.
- R2: hsync is 1 exactly while the pixel count is in 210..241, that is from H_ACTIVE+H_FRONT up to H_ACTIVE+H_FRONT+H_SYNC−1. It is 0 at every other count.
- R3: The line count changes only on the clock after the pixel count was at its last value. At that clock it steps by one, and it returns to 0 after line 627.
- R4: vsync is 1 exactly while the line count is in 601..604, that is from V_ACTIVE+V_FRONT up to V_ACTIVE+V_FRONT+V_SYNC−1. It is 0 on every other line.
- R5: de is 1 exactly when the pixel count is below 200 (H_ACTIVE) and the line count is below 600 (V_ACTIVE).
- R6: While rst_n is low at a clock edge, both counts go to 0, hsync, vsync and frame_end go to 0, and de goes to 1. The first clock after reset therefore shows visible pixel (0,0).
- R7: frame_end is 1 for exactly one clock per frame: the clock where the pixel count is 263 and the line count is 627.
- R8: Pulling rst_n low in the middle of a frame restarts the timing at pixel (0,0). The frames that follow are identical to the frames that follow a power-on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync | output | 1 | Horizontal sync, active high, registered |
| vsync | output | 1 | Vertical sync, active high, registered |
| de | output | 1 | Display enable, high on visible pixels |
| h_count | output | 9 | Pixel position within the line |
| v_count | output | 10 | Line position within the frame |
| frame_end | output | 1 | One-clock strobe on the last pixel of a frame |

## Verification
Apart from the clock, the only input is reset. The assertions therefore assume only that rst_n is held low for at least one clock edge before any output is trusted, and they are disabled while rst_n is low. The stimulus honours this at start-up and again for a reset forced in mid-frame. Between those resets the block runs free.

A reduced geometry (13 clocks per line, 10 lines per frame) is swept over every pixel of several whole frames. Each output is compared at every clock against values the bench computes arithmetically from its own pixel and line model. A second instance with the default geometry is checked over more than one full scanline, including the first step of its line count.

// File: rtl/scan_pkg.sv
// Shared helpers for the scan timing generator.
// Assumes counts are positive integers that fit in 32 bits.
package scan_pkg;
    // Number of bits needed to hold the values 0..n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/scan_counter.sv
// Modulo-MAX counter that advances when step is high.
// Outputs the current value, the value it will take at the next edge,
// and a combinational wrap flag.
// Assumes MAX >= 2 and a synchronous active-low reset.
module scan_counter #(
    parameter int MAX = 264,
    parameter int W   = scan_pkg::cnt_width(MAX)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(MAX - 1);

    // Detect the last value while the counter is stepping.
    always_comb begin
        wrap = step && (cnt == LAST);
    end

    // Work out the value for the next edge.
    always_comb begin
        if (wrap)
            cnt_next = '0;
        else if (step)
            cnt_next = cnt + 1'b1;
        else
            cnt_next = cnt;
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_next;
    end

    // R1 / R3: the count never goes past its last value.
    assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R1 / R3: stepping from the last value returns the count to zero.
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/region_flag.sv
// Set/clear register for one timing interval.
// It is set when probe equals SET_AT and cleared when probe equals CLR_AT.
// probe is the counter's next value, so the flag lines up with the
// registered count.
// Assumes SET_AT differs from CLR_AT.
module region_flag #(
    parameter int W      = 9,
    parameter int SET_AT = 0,
    parameter int CLR_AT = 1,
    parameter bit INIT   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] probe,
    output logic         flag
);
    localparam logic [W-1:0] SET_V = W'(SET_AT);
    localparam logic [W-1:0] CLR_V = W'(CLR_AT);

    // Set on entry to the interval, clear on exit, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= INIT;
        else if (probe == SET_V)
            flag <= 1'b1;
        else if (probe == CLR_V)
            flag <= 1'b0;
    end

    // R5: the flag keeps its value unless probe reaches a boundary.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (probe != SET_V && probe != CLR_V) |=> $stable(flag));
endmodule

// File: rtl/scan_timing_gen.sv
// Raster timing generator for an 800x600, 60 Hz mode whose horizontal
// timing is scaled down to suit a 10 MHz pixel clock.
// A pixel counter drives a line counter. Every interval is a set/clear
// register fed by equality decodes of the next count.
// Assumes every interval parameter is at least 1 and rst_n is
// synchronous and active low.
module scan_timing_gen #(
    parameter int H_ACTIVE = 200,
    parameter int H_FRONT  = 10,
    parameter int H_SYNC   = 32,
    parameter int H_BACK   = 22,
    parameter int V_ACTIVE = 600,
    parameter int V_FRONT  = 1,
    parameter int V_SYNC   = 4,
    parameter int V_BACK   = 23,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = scan_pkg::cnt_width(H_TOTAL),
    localparam int VW      = scan_pkg::cnt_width(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [HW-1:0] h_count,
    output logic [VW-1:0] v_count,
    output logic          frame_end
);
    localparam int HS_START = H_ACTIVE + H_FRONT;
    localparam int HS_END   = HS_START + H_SYNC;
    localparam int VS_START = V_ACTIVE + V_FRONT;
    localparam int VS_END   = VS_START + V_SYNC;

    logic [HW-1:0] h_next;
    logic [VW-1:0] v_next;
    logic          h_wrap;
    logic          v_wrap;
    logic          h_vis;
    logic          v_vis;
    logic          eof_q;

    scan_counter #(.MAX(H_TOTAL), .W(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .cnt(h_count), .cnt_next(h_next), .wrap(h_wrap)
    );

    scan_counter #(.MAX(V_TOTAL), .W(VW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .cnt(v_count), .cnt_next(v_next), .wrap(v_wrap)
    );

    region_flag #(.W(HW), .SET_AT(0), .CLR_AT(H_ACTIVE), .INIT(1'b1)) u_hvis (
        .clk(clk), .rst_n(rst_n), .probe(h_next), .flag(h_vis)
    );

    region_flag #(.W(HW), .SET_AT(HS_START), .CLR_AT(HS_END), .INIT(1'b0)) u_hsync (
        .clk(clk), .rst_n(rst_n), .probe(h_next), .flag(hsync)
    );

    region_flag #(.W(VW), .SET_AT(0), .CLR_AT(V_ACTIVE), .INIT(1'b1)) u_vvis (
        .clk(clk), .rst_n(rst_n), .probe(v_next), .flag(v_vis)
    );

    region_flag #(.W(VW), .SET_AT(VS_START), .CLR_AT(VS_END), .INIT(1'b0)) u_vsync (
        .clk(clk), .rst_n(rst_n), .probe(v_next), .flag(vsync)
    );

    // Raise the end-of-frame strobe when the next pixel is the last of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eof_q <= 1'b0;
        else
            eof_q <= (h_next == HW'(H_TOTAL - 1)) && (v_next == VW'(V_TOTAL - 1));
    end

    // Combine the two visible flags into display enable.
    always_comb begin
        de        = h_vis && v_vis;
        frame_end = eof_q;
    end

    // R2: hsync matches a range test on the pixel count.
    assert_hsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hsync == ((h_count >= HW'(HS_START)) && (h_count < HW'(HS_END))));

    // R4: vsync matches a range test on the line count.
    assert_vsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync == ((v_count >= VW'(VS_START)) && (v_count < VW'(VS_END))));

    // R5: display enable matches the visible rectangle.
    assert_de_R5: assert property (@(posedge clk) disable iff (!rst_n)
        de == ((h_count < HW'(H_ACTIVE)) && (v_count < VW'(V_ACTIVE))));

    // R3: the line count holds unless the pixel count wraps.
    assert_vstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wrap |=> $stable(v_count));

    // R7: the strobe appears only on the final pixel of the frame.
    assert_eof_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (h_count == HW'(H_TOTAL - 1) && v_count == VW'(V_TOTAL - 1)));

    // R7: the strobe lasts a single clock.
    assert_eof_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R7: the strobe comes with every wrap of both counters.
    assert_eof_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |-> frame_end);
endmodule

// File: tb/sim_scan_timing_gen.sv
// Bench: full-frame sweep of a reduced geometry plus a line of the default one.
module sim_scan_timing_gen;
    localparam int HA = 6, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 2, VB = 3;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs0, vs0, de0, eof0;
    logic [3:0] hc0;
    logic [3:0] vc0;
    logic hs1, vs1, de1, eof1;
    logic [8:0] hc1;
    logic [9:0] vc1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scan_timing_gen #(.H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
                      .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hs0), .vsync(vs0), .de(de0),
        .h_count(hc0), .v_count(vc0), .frame_end(eof0)
    );

    scan_timing_gen u1 (
        .clk(clk), .rst_n(rst_n), .hsync(hs1), .vsync(vs1), .de(de1),
        .h_count(hc1), .v_count(vc1), .frame_end(eof1)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every output of the reduced instance with the bench model.
    task automatic check_small(input int eh, input int ev, input string pfx);
        check({pfx, " R1 h_count"}, int'(hc0), eh);
        check({pfx, " R3 v_count"}, int'(vc0), ev);
        check({pfx, " R2 hsync"}, int'(hs0), int'(eh >= HA + HF && eh < HA + HF + HS));
        check({pfx, " R4 vsync"}, int'(vs0), int'(ev >= VA + VF && ev < VA + VF + VS));
        check({pfx, " R5 de"}, int'(de0), int'(eh < HA && ev < VA));
        check({pfx, " R7 frame_end"}, int'(eof0), int'(eh == HT - 1 && ev == VT - 1));
    endtask

    initial begin
        int eh, ev, dh, dv;
        repeat (3) @(negedge clk);
        // R6: reset state, sampled while reset is still held.
        check("R6 reset h_count", int'(hc0), 0);
        check("R6 reset v_count", int'(vc0), 0);
        check("R6 reset hsync", int'(hs0), 0);
        check("R6 reset vsync", int'(vs0), 0);
        check("R6 reset de", int'(de0), 1);
        check("R6 reset frame_end", int'(eof0), 0);
        check("R6 reset default de", int'(de1), 1);
        rst_n = 1'b1;
        eh = 0; ev = 0; dh = 0; dv = 0;
        // Sweep three full frames, and the default instance alongside.
        for (int k = 0; k < 3 * HT * VT; k++) begin
            check_small(eh, ev, "sweep");
            check("R1 default h_count", int'(hc1), dh);
            check("R3 default v_count", int'(vc1), dv);
            check("R2 default hsync", int'(hs1), int'(dh >= 210 && dh < 242));
            check("R5 default de", int'(de1), int'(dh < 200));
            check("R4 default vsync", int'(vs1), 0);
            @(negedge clk);
            eh++;
            if (eh == HT) begin
                eh = 0;
                ev = (ev == VT - 1) ? 0 : ev + 1;
            end
            dh++;
            if (dh == 264) begin
                dh = 0;
                dv++;
            end
        end
        // R8: reset in the middle of a frame, then sweep one frame again.
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_small(0, 0, "R8 midreset");
        rst_n = 1'b1;
        eh = 0; ev = 0;
        for (int k = 0; k < HT * VT + 5; k++) begin
            check_small(eh, ev, "R8 after");
            @(negedge clk);
            eh++;
            if (eh == HT) begin
                eh = 0;
                ev = (ev == VT - 1) ? 0 : ev + 1;
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule